// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

An 8-bit timer/counter with two compare channels, A (index 0) and B (index 1). Each channel drives one output pin. A three-bit counting-mode input selects the counting pattern:

- free-running;
- clear-on-compare-A;
- single-slope PWM;
- dual-slope PWM, which counts up and then down.

For each channel, a two-bit code decides which events change the channel's output register: a compare match, BOTTOM or TOP. The code's meaning depends on the counting mode. A per-pin direction bit gates the pin driver. The block is intended to sit behind a register file that holds the mode, compare and direction values. All inputs are used as they are, with no buffering.

The counter carries a two-state direction machine with states DIR_UP and DIR_DOWN:

- In dual-slope mode, DIR_UP moves to DIR_DOWN when the count reaches TOP.
- In dual-slope mode, DIR_DOWN moves back to DIR_UP when the count reaches zero.
- In every other mode the machine is forced to DIR_UP.

The channel logic uses an "effective direction": up at zero, down at TOP, and otherwise the state. This makes a compare value of zero or TOP give a flat output.

Each channel's output register changes only on the clock edge at which its condition is seen on the current count.

Top module: `tmr_wave_top`

## Requirements
- R1: Counting mode is set by wgm_i[1:0]:
  - 00: free-running, 0 to 255 and wrap.
  - 10: clear-on-compare. The count returns to 0 on the edge after it equals cmp_a_i.
  - 11: single-slope. The count goes 0 to TOP and wraps to 0.
  - 01: dual-slope. The count goes 0 up to TOP and back down to 0.
  - TOP is 255. In the two PWM modes with wgm_i[2]=1, TOP is cmp_a_i instead.
- R2: While rst_n is low, tcnt_o is 0, the output registers are 0 and pin_o is 0. The direction state is DIR_UP.
- R3: A channel code of 00 gives ovr_o=0 and pin_o=0 for that channel in every counting mode.
- R4: drv_o is ovr_o AND ddr_i per channel. pin_o equals the channel's output register when drv_o is 1, and 0 otherwise.
- R5: In the non-PWM modes (00, 10), codes 01, 10 and 11 act on a compare match (count equals the channel's compare value) as follows: 01 toggles, 10 clears and 11 sets. This holds for both channels.
- R6: Single-slope code 10 clears on match and sets at BOTTOM, and the match wins when both occur at once. The output is therefore high for C of every TOP+1 cycles, where C is the compare value. Code 11 is the inverse.
- R7: In dual-slope mode, code 10 clears on a match while the effective direction is up and sets on a match while it is down. The output is high for 2C of every 2·TOP cycles. Code 11 is the inverse.
- R8: In either PWM mode, code 01 behaves as follows:
  - Channel A toggles on compare match when wgm_i[2]=1 (ovr_o[0]=1).
  - Channel A is disconnected when wgm_i[2]=0 (ovr_o[0]=0).
  - Channel B is always disconnected (ovr_o[1]=0).
- R9: In a PWM mode with cmp_a_i equal to TOP and com_a_i[1]=1, channel A ignores the match. At TOP it drives its BOTTOM level instead (high for code 10, low for code 11), so the output is flat.
- R10: An output register changes on the clock edge at which its condition holds on the count presented before that edge. The pin therefore shows the new value together with the next count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wgm_i | input | 3 | Counting mode [1:0] and TOP select [2] |
| cmp_a_i | input | 8 | Compare value, channel A |
| cmp_b_i | input | 8 | Compare value, channel B |
| com_a_i | input | 2 | Output action code, channel A |
| com_b_i | input | 2 | Output action code, channel B |
| ddr_i | input | 2 | Pin direction bits, [0]=A, [1]=B |
| tcnt_o | output | 8 | Current count |
| ovr_o | output | 2 | Timer owns the pin, per channel |
| drv_o | output | 2 | Pin driver enabled, per channel |
| pin_o | output | 2 | Pin values, per channel |

## Verification
The assertions check the following on every cycle:

- the counter's wrap and clear steps;
- the one-step descent in dual-slope mode;
- the BOTTOM set and up-count clear in the PWM modes;
- the flat output in the compare-A-equals-TOP case;
- the toggle in non-PWM mode;
- gating of the pin by the direction bit.

Duty cycle and polarity over whole periods can only be shown by the bench's scenarios. The same applies to the exact edge at which a pin changes, to code 00 disconnection in each mode, and to the channel-A-only toggle for code 01.

// File: rtl/tmr_wave_pkg.sv
`timescale 1ns/1ps
package tmr_wave_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_PHASE  = 2'b01,
        MODE_CTC    = 2'b10,
        MODE_FAST   = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_CLEAR,
        ACT_SET,
        ACT_TOGGLE
    } oc_act_e;

    localparam logic [1:0] COM_OFF  = 2'b00;
    localparam logic [1:0] COM_ALT  = 2'b01;
    localparam logic [1:0] COM_LOW  = 2'b10;
    localparam logic [1:0] COM_HIGH = 2'b11;
endpackage

// File: rtl/tmr_wave_cnt.sv
`timescale 1ns/1ps
module tmr_wave_cnt
    import tmr_wave_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode_i,
    input  logic             top_sel_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] top_o,
    output logic             at_top_o,
    output logic             at_bottom_o,
    output dir_e             dir_eff_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    dir_e             dir_q, dir_d;

    always_comb begin
        top_o = CNT_MAX;
        if ((mode_i == MODE_FAST || mode_i == MODE_PHASE) && top_sel_i)
            top_o = cmp_a_i;
        else if (mode_i == MODE_CTC)
            top_o = cmp_a_i;
    end

    assign at_bottom_o = (cnt_q == '0);
    assign at_top_o    = (cnt_q >= top_o);
    assign cnt_o       = cnt_q;

    always_comb begin
        dir_d = DIR_UP;
        cnt_d = cnt_q + ONE;
        unique case (mode_i)
            MODE_NORMAL: ;
            MODE_CTC:    if (cnt_q == cmp_a_i) cnt_d = '0;
            MODE_FAST:   if (at_top_o) cnt_d = '0;
            MODE_PHASE: begin
                unique case (dir_q)
                    DIR_UP: begin
                        if (at_top_o) begin
                            dir_d = DIR_DOWN;
                            cnt_d = at_bottom_o ? '0 : cnt_q - ONE;
                        end
                    end
                    DIR_DOWN: begin
                        if (at_bottom_o) begin
                            dir_d = DIR_UP;
                            cnt_d = at_top_o ? '0 : ONE;
                        end else begin
                            dir_d = DIR_DOWN;
                            cnt_d = cnt_q - ONE;
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    always_comb begin
        dir_eff_o = DIR_UP;
        if (mode_i == MODE_PHASE) begin
            if (at_bottom_o)   dir_eff_o = DIR_UP;
            else if (at_top_o) dir_eff_o = DIR_DOWN;
            else               dir_eff_o = dir_q;
        end
    end

    assert_fast_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FAST && cnt_q == top_o) |=> (cnt_q == '0));

    assert_ctc_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_CTC && cnt_q == cmp_a_i) |=> (cnt_q == '0));

    assert_phase_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PHASE && dir_q == DIR_DOWN && !at_bottom_o)
        |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/tmr_wave_chan.sv
`timescale 1ns/1ps
module tmr_wave_chan
    import tmr_wave_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter bit IS_A  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode_i,
    input  logic             top_sel_i,
    input  logic [1:0]       code_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             at_top_i,
    input  logic             at_bottom_i,
    input  dir_e             dir_eff_i,
    input  logic             ddr_i,
    output logic             ovr_o,
    output logic             drv_o,
    output logic             pin_o
);
    logic    oc_q;
    logic    match, pwm, special;
    oc_act_e act, hit_act, bot_act;

    assign match   = (cnt_i == cmp_i);
    assign pwm     = (mode_i == MODE_FAST) || (mode_i == MODE_PHASE);
    assign special = IS_A && pwm && code_i[1] && (cmp_i == top_i);
    assign hit_act = (code_i == COM_LOW) ? ACT_CLEAR : ACT_SET;
    assign bot_act = (code_i == COM_LOW) ? ACT_SET : ACT_CLEAR;

    always_comb begin
        act   = ACT_NONE;
        ovr_o = (code_i != COM_OFF);
        unique case (mode_i)
            MODE_NORMAL, MODE_CTC: begin
                if (match) begin
                    unique case (code_i)
                        COM_OFF:  act = ACT_NONE;
                        COM_ALT:  act = ACT_TOGGLE;
                        COM_LOW:  act = ACT_CLEAR;
                        COM_HIGH: act = ACT_SET;
                    endcase
                end
            end
            MODE_FAST, MODE_PHASE: begin
                if (code_i == COM_ALT) begin
                    if (IS_A && top_sel_i) begin
                        if (match) act = ACT_TOGGLE;
                    end else begin
                        ovr_o = 1'b0;
                    end
                end else if (code_i != COM_OFF) begin
                    if (mode_i == MODE_FAST) begin
                        if (match && !special)
                            act = hit_act;
                        else if (at_bottom_i || (special && at_top_i))
                            act = bot_act;
                    end else begin
                        if (special) begin
                            if (at_top_i) act = bot_act;
                        end else if (match) begin
                            act = (dir_eff_i == DIR_UP) ? hit_act : bot_act;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_q <= 1'b0;
        end else begin
            unique case (act)
                ACT_NONE:   ;
                ACT_CLEAR:  oc_q <= 1'b0;
                ACT_SET:    oc_q <= 1'b1;
                ACT_TOGGLE: oc_q <= ~oc_q;
            endcase
        end
    end

    assign drv_o = ovr_o & ddr_i;
    assign pin_o = drv_o & oc_q;

    assert_fast_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FAST && code_i == COM_LOW && at_bottom_i && !match) |=> oc_q);

    assert_phase_up_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PHASE && code_i == COM_LOW && match && !special
         && dir_eff_i == DIR_UP) |=> !oc_q);

    assert_top_flat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (special && code_i == COM_LOW && at_top_i) |=> oc_q);

    assert_nonpwm_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && code_i == COM_ALT && match) |=> (oc_q != $past(oc_q)));
endmodule

// File: rtl/tmr_wave_top.sv
`timescale 1ns/1ps
module tmr_wave_top
    import tmr_wave_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       wgm_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    input  logic [1:0]       com_a_i,
    input  logic [1:0]       com_b_i,
    input  logic [1:0]       ddr_i,
    output logic [CNT_W-1:0] tcnt_o,
    output logic [1:0]       ovr_o,
    output logic [1:0]       drv_o,
    output logic [1:0]       pin_o
);
    localparam int NUM_CH = 2;

    cnt_mode_e        mode;
    logic [CNT_W-1:0] top;
    logic             at_top, at_bottom;
    dir_e             dir_eff;
    logic [CNT_W-1:0] cmp_arr [NUM_CH];
    logic [1:0]       code_arr [NUM_CH];

    assign mode        = cnt_mode_e'(wgm_i[1:0]);
    assign cmp_arr[0]  = cmp_a_i;
    assign cmp_arr[1]  = cmp_b_i;
    assign code_arr[0] = com_a_i;
    assign code_arr[1] = com_b_i;

    tmr_wave_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .top_sel_i  (wgm_i[2]),
        .cmp_a_i    (cmp_a_i),
        .cnt_o      (tcnt_o),
        .top_o      (top),
        .at_top_o   (at_top),
        .at_bottom_o(at_bottom),
        .dir_eff_o  (dir_eff)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_wave_chan #(.CNT_W(CNT_W), .IS_A(g == 0)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode),
            .top_sel_i  (wgm_i[2]),
            .code_i     (code_arr[g]),
            .cmp_i      (cmp_arr[g]),
            .cnt_i      (tcnt_o),
            .top_i      (top),
            .at_top_i   (at_top),
            .at_bottom_i(at_bottom),
            .dir_eff_i  (dir_eff),
            .ddr_i      (ddr_i[g]),
            .ovr_o      (ovr_o[g]),
            .drv_o      (drv_o[g]),
            .pin_o      (pin_o[g])
        );

        assert_ddr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !ddr_i[g] |-> (!pin_o[g] && !drv_o[g]));
    end
endmodule

// File: tb/tmr_wave_top_tb.sv
`timescale 1ns/1ps
module tmr_wave_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] wgm = '0;
    logic [7:0] cmp_a = '0, cmp_b = '0;
    logic [1:0] com_a = '0, com_b = '0, ddr = 2'b11;
    logic [7:0] tcnt;
    logic [1:0] ovr, drv, pin;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    tmr_wave_top u_dut (
        .clk(clk), .rst_n(rst_n), .wgm_i(wgm), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
        .com_a_i(com_a), .com_b_i(com_b), .ddr_i(ddr),
        .tcnt_o(tcnt), .ovr_o(ovr), .drv_o(drv), .pin_o(pin)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [2:0] w, input logic [7:0] ca, input logic [7:0] cb,
                         input logic [1:0] ma, input logic [1:0] mb, input logic [1:0] dd);
        @(negedge clk);
        rst_n = 1'b0;
        wgm = w; cmp_a = ca; cmp_b = cb; com_a = ma; com_b = mb; ddr = dd;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic highs(input int ch, input int settle, input int n, output int hi);
        repeat (settle) @(negedge clk);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi += int'(pin[ch]);
        end
    endtask

    task automatic max_cnt(input int n, output int mx);
        mx = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int'(tcnt) > mx) mx = int'(tcnt);
        end
    endtask

    task automatic wait_cnt(input int v);
        for (int i = 0; i < 600 && int'(tcnt) != v; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        setup(3'b111, 8'd9, 8'd3, 2'b10, 2'b10, 2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 count in reset", int'(tcnt), 0);
        chk("R2 pins in reset", int'(pin), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_counter();
        int mx;
        setup(3'b111, 8'd9, 8'd0, 2'b00, 2'b00, 2'b11);
        max_cnt(40, mx);
        chk("R1 fast top", mx, 9);
        wait_cnt(9); @(negedge clk);
        chk("R1 fast wrap", int'(tcnt), 0);
        setup(3'b010, 8'd5, 8'd0, 2'b00, 2'b00, 2'b11);
        max_cnt(40, mx);
        chk("R1 ctc bound", mx, 5);
        setup(3'b101, 8'd7, 8'd0, 2'b00, 2'b00, 2'b11);
        max_cnt(40, mx);
        chk("R1 phase top", mx, 7);
        wait_cnt(7); @(negedge clk);
        chk("R1 phase descend", int'(tcnt), 6);
        setup(3'b000, 8'd5, 8'd0, 2'b00, 2'b00, 2'b11);
        max_cnt(300, mx);
        chk("R1 normal full range", mx, 255);
    endtask

    task automatic t_nonpwm();
        int hi;
        setup(3'b010, 8'd4, 8'd2, 2'b01, 2'b10, 2'b11);
        highs(0, 20, 20, hi);
        chk("R5 ctc A toggle", hi, 10);
        highs(1, 0, 10, hi);
        chk("R5 ctc B clear", hi, 0);
        setup(3'b010, 8'd4, 8'd2, 2'b01, 2'b11, 2'b11);
        highs(1, 20, 10, hi);
        chk("R5 ctc B set", hi, 10);
        setup(3'b010, 8'd4, 8'd2, 2'b00, 2'b01, 2'b11);
        highs(1, 20, 20, hi);
        chk("R5 ctc B toggle", hi, 10);
        setup(3'b000, 8'd0, 8'd16, 2'b00, 2'b01, 2'b11);
        highs(1, 20, 512, hi);
        chk("R5 normal B toggle", hi, 256);
    endtask

    task automatic t_fast();
        int hi;
        setup(3'b111, 8'd9, 8'd3, 2'b00, 2'b10, 2'b11);
        highs(1, 30, 20, hi);
        chk("R6 fast noninv C=3", hi, 6);
        setup(3'b111, 8'd9, 8'd3, 2'b00, 2'b11, 2'b11);
        highs(1, 30, 20, hi);
        chk("R6 fast inv C=3", hi, 14);
        setup(3'b111, 8'd9, 8'd0, 2'b00, 2'b10, 2'b11);
        highs(1, 30, 20, hi);
        chk("R6 fast C=0", hi, 0);
        setup(3'b111, 8'd9, 8'd9, 2'b00, 2'b10, 2'b11);
        highs(1, 30, 20, hi);
        chk("R6 fast B C=TOP", hi, 18);
        setup(3'b011, 8'd0, 8'd64, 2'b00, 2'b10, 2'b11);
        highs(1, 260, 256, hi);
        chk("R6 fast TOP=255 C=64", hi, 64);
    endtask

    task automatic t_phase();
        int hi;
        setup(3'b101, 8'd10, 8'd4, 2'b00, 2'b10, 2'b11);
        highs(1, 40, 40, hi);
        chk("R7 phase noninv C=4", hi, 16);
        setup(3'b101, 8'd10, 8'd4, 2'b00, 2'b11, 2'b11);
        highs(1, 40, 40, hi);
        chk("R7 phase inv C=4", hi, 24);
        setup(3'b101, 8'd10, 8'd0, 2'b00, 2'b10, 2'b11);
        highs(1, 40, 40, hi);
        chk("R7 phase C=0", hi, 0);
        setup(3'b101, 8'd10, 8'd10, 2'b00, 2'b10, 2'b11);
        highs(1, 40, 40, hi);
        chk("R7 phase C=TOP", hi, 40);
    endtask

    task automatic t_special();
        int hi;
        setup(3'b111, 8'd9, 8'd0, 2'b10, 2'b00, 2'b11);
        highs(0, 30, 20, hi);
        chk("R9 fast A=TOP code10", hi, 20);
        setup(3'b111, 8'd9, 8'd0, 2'b11, 2'b00, 2'b11);
        highs(0, 30, 20, hi);
        chk("R9 fast A=TOP code11", hi, 0);
        setup(3'b101, 8'd10, 8'd0, 2'b11, 2'b00, 2'b11);
        highs(0, 40, 40, hi);
        chk("R9 phase A=TOP code11", hi, 0);
    endtask

    task automatic t_alt();
        int hi;
        setup(3'b111, 8'd9, 8'd3, 2'b01, 2'b01, 2'b11);
        highs(0, 30, 20, hi);
        chk("R8 fast A toggle", hi, 10);
        chk("R8 fast A owns pin", int'(ovr[0]), 1);
        chk("R8 fast B disconnected", int'(ovr[1]), 0);
        highs(1, 0, 20, hi);
        chk("R8 fast B pin idle", hi, 0);
        setup(3'b011, 8'd9, 8'd3, 2'b01, 2'b00, 2'b11);
        highs(0, 30, 20, hi);
        chk("R8 fast A no top-sel", int'(ovr[0]) + hi, 0);
        setup(3'b101, 8'd10, 8'd3, 2'b01, 2'b01, 2'b11);
        highs(0, 40, 40, hi);
        chk("R8 phase A toggle", hi, 20);
        chk("R8 phase B disconnected", int'(ovr[1]), 0);
    endtask

    task automatic t_off();
        int hi;
        logic [2:0] modes [4] = '{3'b000, 3'b010, 3'b111, 3'b101};
        for (int m = 0; m < 4; m++) begin
            setup(modes[m], 8'd9, 8'd3, 2'b00, 2'b00, 2'b11);
            highs(0, 10, 30, hi);
            chk($sformatf("R3 code00 mode %0d ovr", m), int'(ovr), 0);
            chk($sformatf("R3 code00 mode %0d pin", m), hi, 0);
        end
    endtask

    task automatic t_ddr();
        int hi;
        setup(3'b111, 8'd9, 8'd3, 2'b00, 2'b10, 2'b01);
        highs(1, 30, 20, hi);
        chk("R4 ddr off pin", hi, 0);
        chk("R4 ddr off ovr", int'(ovr[1]), 1);
        chk("R4 ddr off drv", int'(drv[1]), 0);
        @(negedge clk); ddr = 2'b11;
        @(negedge clk);
        chk("R4 ddr on drv", int'(drv[1]), 1);
    endtask

    task automatic t_edge();
        setup(3'b111, 8'd9, 8'd3, 2'b00, 2'b10, 2'b11);
        repeat (12) @(negedge clk);
        wait_cnt(3);
        chk("R10 high at match count", int'(pin[1]), 1);
        @(negedge clk);
        chk("R10 low after match edge", int'(pin[1]), 0);
        wait_cnt(0);
        chk("R10 low at bottom count", int'(pin[1]), 0);
        @(negedge clk);
        chk("R10 high after bottom edge", int'(pin[1]), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_counter();
        t_nonpwm();
        t_fast();
        t_phase();
        t_special();
        t_alt();
        t_off();
        t_ddr();
        t_edge();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule